// File: doc/BRIEF.md
# Multiply and Multiply-Add Unit

This block is a fully pipelined integer multiplier for a 64-bit datapath. Every operation runs through one shared path. Both multiplicands are widened to 128 bits, by sign or zero extension as the selected operation needs. An optional third operand, also widened, is added to the product. One 64-bit slice of the 128-bit sum then becomes the result. This single path covers several operations:

- the low doubleword product;
- the signed and unsigned high doubleword products;
- products of 32-bit words;
- a product with a sign-extended 16-bit immediate;
- high and low multiply-add.

A caller raises `start_i` for one cycle with an operation code and operands. A new operation may be issued every cycle. Exactly three clock edges later, `valid_o` is high for one cycle with the matching result. The two low-product forms can report overflow when overflow reporting is requested. A sticky summary flag gathers every overflow seen since reset.

Top module: `mul_unit`

## Requirements
- R1: An operation accepted when `start_i` is high at a rising edge produces exactly one `valid_o` cycle, three rising edges later. Operations issued on consecutive cycles come back in order on consecutive cycles.
- R2: Code 0 returns the low 64 bits of `a_i * b_i`.
- R3: Code 1 returns bits 127..64 of the signed 128-bit product `a_i * b_i`. Code 2 returns bits 127..64 of the unsigned product.
- R4: Code 3 returns the full signed 64-bit product of the low 32 bits of `a_i` and `b_i`. The upper 32 bits of both inputs have no effect.
- R5: Code 4 (signed) and code 5 (unsigned) multiply the low 32 bits of `a_i` and `b_i`. They put bits 63..32 of the 64-bit product in `result_o[31:0]` and drive `result_o[63:32]` to zero.
- R6: Code 6 returns the low 64 bits of `a_i` times `imm_i` sign-extended from bit 15. `b_i` has no effect.
- R7: Code 7 returns bits 127..64 of (signed product + `c_i` sign-extended to 128 bits). Code 8 returns bits 127..64 of (unsigned product + `c_i` zero-extended).
- R8: Code 9 returns bits 63..0 of (signed product + `c_i` sign-extended).
- R9: For codes 0 and 3 with `oe_i` high, `ov_o` and `ov32_o` are both 1 when the signed product does not fit in 64 bits (code 0) or in 32 bits (code 3). In every other case, and in every cycle without `valid_o`, both are 0.
- R10: `so_o` becomes 1 in the cycle that `ov_o` is 1 and stays 1 until reset.
- R11: Codes 10 to 15 return a zero result with no overflow.
- R12: While `rst_ni` is low, `valid_o`, `result_o`, `ov_o`, `ov32_o` and `so_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Accept an operation this cycle |
| op_i | input | 4 | Operation code (see R2 to R11) |
| oe_i | input | 1 | Request overflow reporting |
| a_i | input | 64 | First multiplicand |
| b_i | input | 64 | Second multiplicand |
| c_i | input | 64 | Addend for the multiply-add forms |
| imm_i | input | 16 | Signed immediate for code 6 |
| valid_o | output | 1 | Result valid, one cycle per operation |
| result_o | output | 64 | Selected 64-bit result |
| ov_o | output | 1 | Overflow of the low forms |
| ov32_o | output | 1 | 32-bit overflow of the low forms |
| so_o | output | 1 | Sticky summary overflow |

## Verification
The bench uses operands with the top bit set. There, a design that mixed up signed and unsigned extension would return high halves that differ by one multiplicand. It drives the word forms with junk in the upper input words. A multiplier that did not mask them would show different results, and a word-high form that leaked the product's upper word would show non-zero upper bits. The bench aims at the overflow boundary exactly: a doubleword product of 2^63, a word product of 2^31, and -1 times -1. An off-by-one range check would flag or miss one of these. It also aims at the multiply-add carry from the low half into the high half with a negative addend, where wrong addend extension changes the high result.

// File: rtl/mul_pkg.sv
package mul_pkg;

  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_MUL_LO     = 4'd0,
    OP_MUL_HI_S   = 4'd1,
    OP_MUL_HI_U   = 4'd2,
    OP_WMUL_LO    = 4'd3,
    OP_WMUL_HI_S  = 4'd4,
    OP_WMUL_HI_U  = 4'd5,
    OP_MUL_IMM    = 4'd6,
    OP_MADD_HI_S  = 4'd7,
    OP_MADD_HI_U  = 4'd8,
    OP_MADD_LO    = 4'd9
  } mul_op_e;

  // low forms that may flag overflow
  function automatic logic op_can_overflow(input logic [OP_W-1:0] op);
    return (op == OP_MUL_LO) || (op == OP_WMUL_LO);
  endfunction

endpackage

// File: rtl/mul_operand_prep.sv
module mul_operand_prep
  import mul_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned IMM_W = 16
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [XLEN-1:0]   a_i,
  input  logic [XLEN-1:0]   b_i,
  input  logic [XLEN-1:0]   c_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [2*XLEN-1:0] a_ext_o,
  output logic [2*XLEN-1:0] b_ext_o,
  output logic [2*XLEN-1:0] add_ext_o
);

  localparam int unsigned W2   = 2 * XLEN;
  localparam int unsigned HALF = XLEN / 2;

  function automatic logic [W2-1:0] widen_full(input logic [XLEN-1:0] v, input logic sgn);
    return {{XLEN{sgn & v[XLEN-1]}}, v};
  endfunction

  function automatic logic [W2-1:0] widen_half(input logic [HALF-1:0] v, input logic sgn);
    return {{(W2-HALF){sgn & v[HALF-1]}}, v};
  endfunction

  function automatic logic [W2-1:0] widen_imm(input logic [IMM_W-1:0] v);
    return {{(W2-IMM_W){v[IMM_W-1]}}, v};
  endfunction

  always_comb begin
    a_ext_o   = '0;
    b_ext_o   = '0;
    add_ext_o = '0;
    case (mul_op_e'(op_i))
      OP_MUL_LO, OP_MUL_HI_S: begin
        a_ext_o = widen_full(a_i, 1'b1);
        b_ext_o = widen_full(b_i, 1'b1);
      end
      OP_MUL_HI_U: begin
        a_ext_o = widen_full(a_i, 1'b0);
        b_ext_o = widen_full(b_i, 1'b0);
      end
      OP_WMUL_LO, OP_WMUL_HI_S: begin
        a_ext_o = widen_half(a_i[HALF-1:0], 1'b1);
        b_ext_o = widen_half(b_i[HALF-1:0], 1'b1);
      end
      OP_WMUL_HI_U: begin
        a_ext_o = widen_half(a_i[HALF-1:0], 1'b0);
        b_ext_o = widen_half(b_i[HALF-1:0], 1'b0);
      end
      OP_MUL_IMM: begin
        a_ext_o = widen_full(a_i, 1'b1);
        b_ext_o = widen_imm(imm_i);
      end
      OP_MADD_HI_S, OP_MADD_LO: begin
        a_ext_o   = widen_full(a_i, 1'b1);
        b_ext_o   = widen_full(b_i, 1'b1);
        add_ext_o = widen_full(c_i, 1'b1);
      end
      OP_MADD_HI_U: begin
        a_ext_o   = widen_full(a_i, 1'b0);
        b_ext_o   = widen_full(b_i, 1'b0);
        add_ext_o = widen_full(c_i, 1'b0);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/mul_core.sv
module mul_core
  import mul_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  input  logic [OP_W-1:0]      in_op_i,
  input  logic                 in_oe_i,
  input  logic [2*XLEN-1:0]    a_ext_i,
  input  logic [2*XLEN-1:0]    b_ext_i,
  input  logic [2*XLEN-1:0]    add_ext_i,
  output logic                 out_valid_o,
  output logic [OP_W-1:0]      out_op_o,
  output logic                 out_oe_o,
  output logic [2*XLEN-1:0]    out_sum_o
);

  localparam int unsigned W2 = 2 * XLEN;

  function automatic logic [W2-1:0] mul_add(input logic [W2-1:0] x, input logic [W2-1:0] y,
                                            input logic [W2-1:0] z);
    return (x * y) + z;
  endfunction

  logic            s1_valid_q;
  logic [OP_W-1:0] s1_op_q;
  logic            s1_oe_q;
  logic [W2-1:0]   s1_a_q, s1_b_q, s1_add_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q <= 1'b0;
      s1_op_q    <= '0;
      s1_oe_q    <= 1'b0;
      s1_a_q     <= '0;
      s1_b_q     <= '0;
      s1_add_q   <= '0;
    end else begin
      s1_valid_q <= in_valid_i;
      if (in_valid_i) begin
        s1_op_q  <= in_op_i;
        s1_oe_q  <= in_oe_i;
        s1_a_q   <= a_ext_i;
        s1_b_q   <= b_ext_i;
        s1_add_q <= add_ext_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_op_o    <= '0;
      out_oe_o    <= 1'b0;
      out_sum_o   <= '0;
    end else begin
      out_valid_o <= s1_valid_q;
      if (s1_valid_q) begin
        out_op_o  <= s1_op_q;
        out_oe_o  <= s1_oe_q;
        out_sum_o <= mul_add(s1_a_q, s1_b_q, s1_add_q);
      end
    end
  end

endmodule

// File: rtl/mul_result_sel.sv
module mul_result_sel
  import mul_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic              oe_i,
  input  logic [2*XLEN-1:0] sum_i,
  output logic [XLEN-1:0]   result_o,
  output logic              ov_o
);

  localparam int unsigned W2   = 2 * XLEN;
  localparam int unsigned HALF = XLEN / 2;

  // true when every bit from the top down to bit (w-1) agrees
  function automatic logic fits_signed(input logic [W2-1:0] v, input int unsigned w);
    logic [W2-1:0] upper;
    upper = v >> (w - 1);
    return (upper == '0) || (upper == ({W2{1'b1}} >> (w - 1)));
  endfunction

  always_comb begin
    result_o = '0;
    ov_o     = 1'b0;
    case (mul_op_e'(op_i))
      OP_MUL_LO: begin
        result_o = sum_i[XLEN-1:0];
        ov_o     = oe_i & ~fits_signed(sum_i, XLEN);
      end
      OP_WMUL_LO: begin
        result_o = sum_i[XLEN-1:0];
        ov_o     = oe_i & ~fits_signed(sum_i, HALF);
      end
      OP_MUL_IMM, OP_MADD_LO:
        result_o = sum_i[XLEN-1:0];
      OP_MUL_HI_S, OP_MUL_HI_U, OP_MADD_HI_S, OP_MADD_HI_U:
        result_o = sum_i[W2-1:XLEN];
      OP_WMUL_HI_S, OP_WMUL_HI_U:
        result_o = {{(XLEN-HALF){1'b0}}, sum_i[XLEN-1:HALF]};
      default: ;
    endcase
  end

endmodule

// File: rtl/mul_unit.sv
module mul_unit
  import mul_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned IMM_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [3:0]         op_i,
  input  logic               oe_i,
  input  logic [XLEN-1:0]    a_i,
  input  logic [XLEN-1:0]    b_i,
  input  logic [XLEN-1:0]    c_i,
  input  logic [IMM_W-1:0]   imm_i,
  output logic               valid_o,
  output logic [XLEN-1:0]    result_o,
  output logic               ov_o,
  output logic               ov32_o,
  output logic               so_o
);

  localparam int unsigned W2 = 2 * XLEN;

  logic [W2-1:0]   a_ext, b_ext, add_ext;
  logic            core_valid;
  logic [OP_W-1:0] core_op;
  logic            core_oe;
  logic [W2-1:0]   core_sum;
  logic [XLEN-1:0] sel_result;
  logic            sel_ov;

  // named events for the checker
  logic evt_result_ready;
  logic evt_overflow;

  mul_operand_prep #(.XLEN(XLEN), .IMM_W(IMM_W)) u_prep (
    .op_i      (op_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .c_i       (c_i),
    .imm_i     (imm_i),
    .a_ext_o   (a_ext),
    .b_ext_o   (b_ext),
    .add_ext_o (add_ext)
  );

  mul_core #(.XLEN(XLEN)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (start_i),
    .in_op_i     (op_i),
    .in_oe_i     (oe_i),
    .a_ext_i     (a_ext),
    .b_ext_i     (b_ext),
    .add_ext_i   (add_ext),
    .out_valid_o (core_valid),
    .out_op_o    (core_op),
    .out_oe_o    (core_oe),
    .out_sum_o   (core_sum)
  );

  mul_result_sel #(.XLEN(XLEN)) u_sel (
    .op_i     (core_op),
    .oe_i     (core_oe),
    .sum_i    (core_sum),
    .result_o (sel_result),
    .ov_o     (sel_ov)
  );

  assign evt_result_ready = core_valid;
  assign evt_overflow     = core_valid & sel_ov & op_can_overflow(core_op);

  logic            valid_q, ov_q, so_q;
  logic [XLEN-1:0] result_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      result_q <= '0;
      ov_q     <= 1'b0;
      so_q     <= 1'b0;
    end else begin
      valid_q <= evt_result_ready;
      ov_q    <= evt_overflow;
      so_q    <= so_q | evt_overflow;
      if (evt_result_ready) result_q <= sel_result;
    end
  end

  assign valid_o  = valid_q;
  assign result_o = result_q;
  assign ov_o     = ov_q;
  assign ov32_o   = ov_q;
  assign so_o     = so_q;

endmodule

// File: rtl/mul_unit_chk.sv
module mul_unit_chk #(
  parameter int unsigned XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic [3:0]      op_i,
  input logic            oe_i,
  input logic            valid_o,
  input logic [XLEN-1:0] result_o,
  input logic            ov_o,
  input logic            ov32_o,
  input logic            so_o,
  input logic            evt_overflow
);

  localparam int unsigned HALF = XLEN / 2;

  // edges seen since reset, saturating at 3
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end
  logic warm;
  assign warm = (age_q == 2'd3);

  p_latency_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm |-> (valid_o == $past(start_i, 3)));

  p_word_hi_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && valid_o && ($past(op_i, 3) == 4'd4 || $past(op_i, 3) == 4'd5))
      |-> (result_o[XLEN-1:HALF] == '0));

  p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && !($past(oe_i, 3) && ($past(op_i, 3) == 4'd0 || $past(op_i, 3) == 4'd3)))
      |-> !ov_o);

  p_ov_only_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !ov_o);

  p_ov_pair_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ov_o == ov32_o);

  p_so_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    so_o |=> so_o);

  p_so_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_overflow |=> (so_o && ov_o));

  p_unknown_op_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && valid_o && $past(op_i, 3) >= 4'd10) |-> (result_o == '0 && !ov_o));

endmodule

bind mul_unit mul_unit_chk #(.XLEN(XLEN)) u_mul_unit_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .op_i         (op_i),
  .oe_i         (oe_i),
  .valid_o      (valid_o),
  .result_o     (result_o),
  .ov_o         (ov_o),
  .ov32_o       (ov32_o),
  .so_o         (so_o),
  .evt_overflow (evt_overflow)
);

// File: tb/test_mul_unit.sv
module test_mul_unit;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  op = '0;
  logic        oe = 1'b0;
  logic [63:0] a = '0, b = '0, c = '0;
  logic [15:0] imm = '0;
  logic        valid;
  logic [63:0] result;
  logic        ov, ov32, so;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic so_model = 1'b0;

  typedef struct {
    logic [63:0] r;
    logic        ov;
    int          due;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mul_unit i_mul_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .oe_i(oe),
    .a_i(a), .b_i(b), .c_i(c), .imm_i(imm),
    .valid_o(valid), .result_o(result), .ov_o(ov), .ov32_o(ov32), .so_o(so)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model written from the requirements
  function automatic void model(input logic [3:0] o, input logic en, input logic [63:0] x,
                                input logic [63:0] y, input logic [63:0] z, input logic [15:0] im,
                                output logic [63:0] r, output logic f);
    logic [127:0] pu, ps, t;
    logic [63:0]  pw, pwu, ie;
    logic signed [63:0] pws;
    pu  = {64'd0, x} * {64'd0, y};
    ps  = pu - {(x[63] ? y : 64'd0), 64'd0} - {(y[63] ? x : 64'd0), 64'd0};
    pws = longint'({{32{x[31]}}, x[31:0]}) * longint'({{32{y[31]}}, y[31:0]});
    pw  = pws;
    pwu = {32'd0, x[31:0]} * {32'd0, y[31:0]};
    ie  = {{48{im[15]}}, im};
    r = '0;
    f = 1'b0;
    case (o)
      4'd0: begin
        r = pu[63:0];
        f = en && !((ps[127:64] == 64'd0 && !ps[63]) || (ps[127:64] == '1 && ps[63]));
      end
      4'd1: r = ps[127:64];
      4'd2: r = pu[127:64];
      4'd3: begin
        r = pw;
        f = en && (pws > 64'sd2147483647 || pws < -64'sd2147483648);
      end
      4'd4: r = {32'd0, pw[63:32]};
      4'd5: r = {32'd0, pwu[63:32]};
      4'd6: begin t = {64'd0, x} * {64'd0, ie}; r = t[63:0]; end
      4'd7: begin t = ps + {{64{z[63]}}, z}; r = t[127:64]; end
      4'd8: begin t = pu + {64'd0, z}; r = t[127:64]; end
      4'd9: begin t = ps + {{64{z[63]}}, z}; r = t[63:0]; end
      default: ;
    endcase
  endfunction

  task automatic issue(input logic [3:0] o, input logic en, input logic [63:0] x,
                       input logic [63:0] y, input logic [63:0] z, input logic [15:0] im,
                       input string tag);
    exp_t e;
    @(negedge clk);
    start = 1'b1; op = o; oe = en; a = x; b = y; c = z; imm = im;
    model(o, en, x, y, z, im, e.r, e.ov);
    e.due = cyc + 3;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R1 spurious valid", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(cyc == e.due, {e.tag, " R1 latency"}, 64'(cyc), 64'(e.due));
          check(result === e.r, {e.tag, " result"}, result, e.r);
          check(ov === e.ov && ov32 === e.ov, {e.tag, " R9 flags"}, {62'd0, ov32, ov}, {62'd0, e.ov, e.ov});
          so_model = so_model | e.ov;
          check(so === so_model, {e.tag, " R10 sticky"}, {63'd0, so}, {63'd0, so_model});
        end
      end else begin
        if (sb.size() != 0 && sb[0].due <= cyc)
          check(1'b0, {sb[0].tag, " R1 missing valid"}, 64'd0, 64'd1);
        if (ov !== 1'b0) check(1'b0, "R9 flag without valid", {63'd0, ov}, 64'd0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(valid === 1'b0 && ov === 1'b0 && ov32 === 1'b0 && so === 1'b0 && result === 64'd0,
          "R12 reset state", {valid, ov, ov32, so, result[59:0]}, 64'd0);
    rst_n = 1'b1;
    idle(2);

    // R2 low doubleword
    issue(4'd0, 1'b1, 64'd3, 64'd5, 64'd0, 16'd0, "R2 small");
    issue(4'd0, 1'b1, '1, '1, 64'd0, 16'd0, "R2 minus one squared");
    idle(4);
    // R3 high halves
    issue(4'd1, 1'b0, '1, '1, 64'd0, 16'd0, "R3 signed high");
    issue(4'd2, 1'b0, '1, '1, 64'd0, 16'd0, "R3 unsigned high");
    issue(4'd1, 1'b0, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 64'd0, 16'd0, "R3 mixed sign");
    // R4 word low, upper junk
    issue(4'd3, 1'b1, 64'hDEAD_BEEF_FFFF_FFFD, 64'h1234_5678_0000_0004, 64'd0, 16'd0, "R4 junk upper");
    // R5 word high
    issue(4'd4, 1'b0, 64'hAAAA_AAAA_FFFF_FFFF, 64'h5555_5555_FFFF_FFFF, 64'd0, 16'd0, "R5 signed");
    issue(4'd5, 1'b0, 64'hAAAA_AAAA_FFFF_FFFF, 64'h5555_5555_FFFF_FFFF, 64'd0, 16'd0, "R5 unsigned");
    // R6 immediate, b ignored
    issue(4'd6, 1'b0, 64'd5, 64'd0, 64'd0, 16'hFFFF, "R6 neg imm b0");
    issue(4'd6, 1'b0, 64'd5, '1, 64'd0, 16'hFFFF, "R6 neg imm b ones");
    issue(4'd6, 1'b0, 64'h1_0000_0000, 64'd77, 64'd0, 16'h7FFF, "R6 pos imm");
    // R7 / R8 multiply-add
    issue(4'd7, 1'b0, 64'd1, 64'd1, 64'hFFFF_FFFF_FFFF_FFFE, 16'd0, "R7 signed neg addend");
    issue(4'd8, 1'b0, 64'd1, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 16'd0, "R7 unsigned carry");
    issue(4'd7, 1'b0, '1, '1, 64'h8000_0000_0000_0000, 16'd0, "R7 signed mix");
    issue(4'd9, 1'b0, 64'd7, 64'd6, 64'hFFFF_FFFF_FFFF_FFF0, 16'd0, "R8 low");
    // R11 unused codes
    issue(4'd12, 1'b1, 64'd9, 64'd9, 64'd9, 16'd9, "R11 code12");
    issue(4'd15, 1'b1, '1, '1, '1, 16'hFFFF, "R11 code15");
    idle(5);
    // R9 boundaries, oe off first (no so yet)
    issue(4'd0, 1'b0, 64'h4000_0000_0000_0000, 64'd2, 64'd0, 16'd0, "R9 oe off");
    issue(4'd3, 1'b1, 64'h0000_0000_4000_0000, 64'd2, 64'd0, 16'd0, "R9 word 2^31");
    issue(4'd3, 1'b1, 64'hFFFF_FFFF_C000_0000, 64'd2, 64'd0, 16'd0, "R9 word -2^31");
    issue(4'd0, 1'b1, 64'h4000_0000_0000_0000, 64'd2, 64'd0, 16'd0, "R9 dword 2^63");
    issue(4'd0, 1'b1, 64'hC000_0000_0000_0000, 64'd2, 64'd0, 16'd0, "R9 dword -2^63");
    issue(4'd1, 1'b1, 64'h4000_0000_0000_0000, 64'd4, 64'd0, 16'd0, "R9 high form no flag");
    issue(4'd0, 1'b1, 64'd3, 64'd3, 64'd0, 16'd0, "R10 so held");
    idle(5);

    // mixed random traffic, some gaps
    for (int i = 0; i < 300; i++) begin
      logic [63:0] ra, rb, rc;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      rc = {$urandom, $urandom};
      if (i % 4 == 1) rb = rb >> (i % 64);
      issue(4'($urandom_range(0, 11)), 1'($urandom), ra, rb, rc, 16'($urandom), "R2-R11 random");
      if (i % 7 == 0) idle(1 + i % 3);
    end
    idle(6);
    check(sb.size() == 0, "R1 drained", 64'(sb.size()), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule